// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle 32-bit RISC processor. It keeps a micro-program counter (the micro-address) that selects one 24-bit microword in a read-only microcode store. Every cycle the control fields of the current microword drive the datapath directly: program-counter source and write enables, ALU operation and operand selects, instruction-register load, memory address select and strobes, write-back source, destination select and register-file write. The store is read combinationally, so the control lines are valid in the same cycle as the micro-address.

The two low bits of each microword pick the next micro-address. The choices are restart at address 0, step to the next address, or jump through a 128-entry dispatch table. The low half of that table is indexed by the instruction opcode. The high half is indexed by the function code, and it is used when the opcode is zero (register format). The microcode store and the dispatch table are computed at elaboration from functions in a package. The word at address 0 performs the shared fetch step and the word at address 1 performs the shared decode step, which ends in a dispatch. A halt microword freezes the sequencer until reset. An illegal sequencing code raises the error output and restarts the sequencer at address 0. Clearing the run input stalls the sequencer.

Top module: `uc_sequencer`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) sets the micro-address to 0. Reset takes priority over halt, run and sequencing.
- R2: The microword bits map to the outputs as follows. Bits 23:22 drive `pc_src`, bit 21 `pc_we`, bit 20 `pc_we_cond`, bits 19:16 `alu_op`, bit 15 `alu_a_sel`, bits 14:13 `alu_b_sel`, bit 12 `ir_we`, bit 11 `mem_addr_sel`, bit 10 `mem_re`, bit 9 `mem_we`, bit 8 `wb_from_mem`, bit 7 `dst_sel_rd`, bit 6 `rf_we`, bit 5 `halt` and bit 4 the error flag. Bits 3:2 are unused. Bits 1:0 hold the sequencing code.
- R3: Sequencing code 00 loads micro-address 0 at the next edge.
- R4: Sequencing code 01 loads the current micro-address plus one at the next edge.
- R5: Sequencing code 10 loads the dispatch-table entry at the next edge. The table index is {1, funct} when `opcode` is 0 and {0, opcode} for any other opcode.
- R6: The word at address 0 is 0x223401 and the word at address 1 is 0x026002. The word at address 1 dispatches.
- R7: These opcodes dispatch to these micro-addresses: 0x08→14, 0x0C→16, 0x0D→18, 0x0A→20, 0x0F→22, 0x23→24, 0x2B→27, 0x04→29, 0x02→30, 0x20→31 and 0x3F→33.
- R8: These function codes (with opcode 0) dispatch to these micro-addresses: 0x20→2, 0x22→4, 0x24→6, 0x25→8, 0x27→10 and 0x2A→12.
- R9: While the current microword has its halt bit set, the micro-address does not change until reset, regardless of `run`.
- R10: Sequencing code 11 is illegal. The `error` output is high while such a word is current, and the next micro-address is 0.
- R11: While `run` is low (and there is no reset), the micro-address holds its value.
- R12: Any opcode or function code not listed in R7 or R8 dispatches to micro-address 32. That word has its error bit set and sequencing code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Sequencer advance enable |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function-code field |
| pc_src | output | 2 | Program-counter source select |
| pc_we | output | 1 | Unconditional program-counter write |
| pc_we_cond | output | 1 | Program-counter write on ALU zero |
| alu_op | output | 4 | ALU operation |
| alu_a_sel | output | 1 | ALU operand A select |
| alu_b_sel | output | 2 | ALU operand B select |
| ir_we | output | 1 | Instruction register load |
| mem_addr_sel | output | 1 | Memory address from ALU result instead of PC |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Register write-back from memory data |
| dst_sel_rd | output | 1 | Destination register from rd field |
| rf_we | output | 1 | Register-file write |
| halt | output | 1 | Halt microword is current |
| error | output | 1 | Error bit set or illegal sequencing code |

## Verification
The bench holds a halt instruction for many cycles with `run` toggling. A sequencer that let halt yield to sequencing would return to fetch, and one that checked `run` ahead of halt would look correct only while `run` stays high. Register-format instructions with unlisted function codes and an opcode that reaches the illegal sequencing word are applied. An index built from the opcode alone would send every register instruction to the same routine, and a sequencer that treated code 11 as a step would run on into whatever word follows. `run` is dropped in the middle of a load routine, so a design that ignored the stall would skip or repeat memory steps. Reset is applied during a halt and during a routine to show that reset overrides both.

// File: rtl/uc_pkg.sv
// Package: shared types and the computed contents of the microcode store
// and dispatch table for the control sequencer.
// Assumes a 24-bit microword and a 12-bit micro-address.
package uc_pkg;

    localparam int UADDR_W = 12;
    localparam int CODE_W  = 6;

    typedef enum logic [1:0] {
        SEQ_RESTART  = 2'b00,
        SEQ_STEP     = 2'b01,
        SEQ_DISPATCH = 2'b10,
        SEQ_ILLEGAL  = 2'b11
    } seq_e;

    typedef struct packed {
        logic [1:0] pc_src;
        logic       pc_we;
        logic       pc_we_cond;
        logic [3:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       ir_we;
        logic       mem_addr_sel;
        logic       mem_re;
        logic       mem_we;
        logic       wb_from_mem;
        logic       dst_sel_rd;
        logic       rf_we;
        logic       halt;
        logic       err;
        logic [1:0] spare;
        seq_e       seq;
    } uword_t;

    // Build one microword from its field values.
    function automatic logic [23:0] mkw(int pcs, int pcw, int pcc, int alu,
                                        int sa, int sb, int irw, int iod,
                                        int mr, int mw, int m2r, int rd,
                                        int rw, int hl, int er, int sq);
        logic [23:0] w;
        w        = '0;
        w[23:22] = 2'(pcs);
        w[21]    = 1'(pcw);
        w[20]    = 1'(pcc);
        w[19:16] = 4'(alu);
        w[15]    = 1'(sa);
        w[14:13] = 2'(sb);
        w[12]    = 1'(irw);
        w[11]    = 1'(iod);
        w[10]    = 1'(mr);
        w[9]     = 1'(mw);
        w[8]     = 1'(m2r);
        w[7]     = 1'(rd);
        w[6]     = 1'(rw);
        w[5]     = 1'(hl);
        w[4]     = 1'(er);
        w[1:0]   = 2'(sq);
        return w;
    endfunction

    // Microcode store contents; unlisted addresses hold zero (restart).
    function automatic logic [23:0] ucode_word(int a);
        logic [23:0] w;
        case (a)
            0:  w = 24'h223401;
            1:  w = 24'h026002;
            2:  w = mkw(0,0,0, 2,1,0,0,0,0,0,0,0,0,0,0,1);
            4:  w = mkw(0,0,0, 6,1,0,0,0,0,0,0,0,0,0,0,1);
            6:  w = mkw(0,0,0, 0,1,0,0,0,0,0,0,0,0,0,0,1);
            8:  w = mkw(0,0,0, 1,1,0,0,0,0,0,0,0,0,0,0,1);
            10: w = mkw(0,0,0,12,1,0,0,0,0,0,0,0,0,0,0,1);
            12: w = mkw(0,0,0, 7,1,0,0,0,0,0,0,0,0,0,0,1);
            3, 5, 7, 9, 11, 13:
                w = mkw(0,0,0, 0,0,0,0,0,0,0,0,1,1,0,0,0);
            14: w = mkw(0,0,0, 2,1,2,0,0,0,0,0,0,0,0,0,1);
            16: w = mkw(0,0,0, 0,1,2,0,0,0,0,0,0,0,0,0,1);
            18: w = mkw(0,0,0, 1,1,2,0,0,0,0,0,0,0,0,0,1);
            20: w = mkw(0,0,0, 7,1,2,0,0,0,0,0,0,0,0,0,1);
            22: w = mkw(0,0,0, 8,1,2,0,0,0,0,0,0,0,0,0,1);
            15, 17, 19, 21, 23:
                w = mkw(0,0,0, 0,0,0,0,0,0,0,0,0,1,0,0,0);
            24, 27:
                w = mkw(0,0,0, 2,1,2,0,0,0,0,0,0,0,0,0,1);
            25: w = mkw(0,0,0, 0,0,0,0,1,1,0,0,0,0,0,0,1);
            26: w = mkw(0,0,0, 0,0,0,0,0,0,0,1,0,1,0,0,0);
            28: w = mkw(0,0,0, 0,0,0,0,1,0,1,0,0,0,0,0,0);
            29: w = mkw(1,0,1, 6,1,0,0,0,0,0,0,0,0,0,0,0);
            30: w = mkw(2,1,0, 0,0,0,0,0,0,0,0,0,0,0,0,0);
            31: w = mkw(0,0,0, 0,0,0,0,0,0,0,0,0,0,1,0,0);
            32: w = mkw(0,0,0, 0,0,0,0,0,0,0,0,0,0,0,1,0);
            33: w = mkw(0,0,0, 0,0,0,0,0,0,0,0,0,0,0,0,3);
            default: w = '0;
        endcase
        return w;
    endfunction

    // Dispatch table: index < 64 is an opcode, index >= 64 is funct + 64.
    function automatic logic [11:0] disp_entry(int idx);
        logic [11:0] t;
        case (idx)
            'h08: t = 12'd14;
            'h0C: t = 12'd16;
            'h0D: t = 12'd18;
            'h0A: t = 12'd20;
            'h0F: t = 12'd22;
            'h23: t = 12'd24;
            'h2B: t = 12'd27;
            'h04: t = 12'd29;
            'h02: t = 12'd30;
            'h20: t = 12'd31;
            'h3F: t = 12'd33;
            64 + 'h20: t = 12'd2;
            64 + 'h22: t = 12'd4;
            64 + 'h24: t = 12'd6;
            64 + 'h25: t = 12'd8;
            64 + 'h27: t = 12'd10;
            64 + 'h2A: t = 12'd12;
            default:   t = 12'd32;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/uc_store.sv
// Microcode store: a read-only array of microwords, filled at elaboration
// from the package function, read combinationally by micro-address.
// Assumes DEPTH covers every address the dispatch table can produce.
module uc_store #(
    parameter int UADDR_W = uc_pkg::UADDR_W,
    parameter int DEPTH   = 64
) (
    input  logic [UADDR_W-1:0] uaddr,
    output uc_pkg::uword_t     word
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [23:0] rom [DEPTH];

    // Fill each store entry from the computed microprogram.
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign rom[g] = uc_pkg::ucode_word(g);
    end

    logic in_range;
    assign in_range = (uaddr < UADDR_W'(DEPTH));

    // Read the current word; addresses past the store read as restart.
    always_comb begin
        word = uc_pkg::uword_t'(24'h0);
        if (in_range) word = uc_pkg::uword_t'(rom[uaddr[IDX_W-1:0]]);
    end
endmodule

// File: rtl/uc_dispatch.sv
// Dispatch table: forms the table index from opcode or function code and
// returns the target micro-address. Assumes opcode 0 means register format.
module uc_dispatch #(
    parameter int UADDR_W = uc_pkg::UADDR_W,
    parameter int CODE_W  = uc_pkg::CODE_W
) (
    input  logic [CODE_W-1:0]  opcode,
    input  logic [CODE_W-1:0]  funct,
    output logic [UADDR_W-1:0] target
);
    localparam int IDX_W   = CODE_W + 1;
    localparam int ENTRIES = 1 << IDX_W;

    logic [UADDR_W-1:0] table_q [ENTRIES];

    // Fill the table from the computed dispatch map.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_fill
        assign table_q[g] = UADDR_W'(uc_pkg::disp_entry(g));
    end

    logic [IDX_W-1:0] idx;

    // Select the function-code half for register-format instructions.
    always_comb begin
        if (opcode == '0) idx = {1'b1, funct};
        else              idx = {1'b0, opcode};
    end

    assign target = table_q[idx];
endmodule

// File: rtl/uc_next.sv
// Micro-program counter and next-address selection.
// Priority: reset, halt hold, run stall, then the sequencing code.
module uc_next #(
    parameter int UADDR_W = uc_pkg::UADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               halt_bit,
    input  uc_pkg::seq_e       seq,
    input  logic [UADDR_W-1:0] disp_target,
    output logic [UADDR_W-1:0] upc
);
    // Advance, hold or restart the micro-address each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc <= '0;
        end else if (halt_bit || !run) begin
            upc <= upc;
        end else begin
            case (seq)
                uc_pkg::SEQ_STEP:     upc <= upc + 1'b1;
                uc_pkg::SEQ_DISPATCH: upc <= disp_target;
                default:              upc <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uc_sequencer.sv
// Top of the microprogrammed control sequencer: store, dispatch table and
// micro-program counter, with the microword fields driven onto the ports.
// Assumes opcode and funct are stable while the decode word is current.
module uc_sequencer #(
    parameter int UADDR_W     = uc_pkg::UADDR_W,
    parameter int CODE_W      = uc_pkg::CODE_W,
    parameter int STORE_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output logic [1:0]        pc_src,
    output logic              pc_we,
    output logic              pc_we_cond,
    output logic [3:0]        alu_op,
    output logic              alu_a_sel,
    output logic [1:0]        alu_b_sel,
    output logic              ir_we,
    output logic              mem_addr_sel,
    output logic              mem_re,
    output logic              mem_we,
    output logic              wb_from_mem,
    output logic              dst_sel_rd,
    output logic              rf_we,
    output logic              halt,
    output logic              error
);
    logic [UADDR_W-1:0] upc;
    logic [UADDR_W-1:0] disp_target;
    uc_pkg::uword_t     word;

    uc_store #(.UADDR_W(UADDR_W), .DEPTH(STORE_DEPTH)) u_store (
        .uaddr (upc),
        .word  (word)
    );

    uc_dispatch #(.UADDR_W(UADDR_W), .CODE_W(CODE_W)) u_dispatch (
        .opcode (opcode),
        .funct  (funct),
        .target (disp_target)
    );

    uc_next #(.UADDR_W(UADDR_W)) u_next (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .halt_bit    (word.halt),
        .seq         (word.seq),
        .disp_target (disp_target),
        .upc         (upc)
    );

    // Drive the control fields of the current microword.
    always_comb begin
        pc_src       = word.pc_src;
        pc_we        = word.pc_we;
        pc_we_cond   = word.pc_we_cond;
        alu_op       = word.alu_op;
        alu_a_sel    = word.alu_a_sel;
        alu_b_sel    = word.alu_b_sel;
        ir_we        = word.ir_we;
        mem_addr_sel = word.mem_addr_sel;
        mem_re       = word.mem_re;
        mem_we       = word.mem_we;
        wb_from_mem  = word.wb_from_mem;
        dst_sel_rd   = word.dst_sel_rd;
        rf_we        = word.rf_we;
        halt         = word.halt;
        error        = word.err || (word.seq == uc_pkg::SEQ_ILLEGAL);
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (upc == '0));

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halt && word.seq == uc_pkg::SEQ_RESTART) |=> (upc == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halt && word.seq == uc_pkg::SEQ_STEP)
        |=> (upc == $past(upc) + 1'b1));

    assert_dispatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halt && word.seq == uc_pkg::SEQ_DISPATCH)
        |=> (upc == $past(disp_target)));

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && $stable(upc)));

    assert_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halt && word.seq == uc_pkg::SEQ_ILLEGAL) |=> (upc == '0));

    assert_illegal_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word.seq == uc_pkg::SEQ_ILLEGAL) |-> error);

    assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(upc));
endmodule

// File: tb/uc_sequencer_bench.sv
`timescale 1ns/1ps
module uc_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic [1:0] pc_src;
    logic       pc_we, pc_we_cond;
    logic [3:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       ir_we, mem_addr_sel, mem_re, mem_we, wb_from_mem;
    logic       dst_sel_rd, rf_we, halt, error;

    always #2.5 clk = ~clk;

    uc_sequencer u_uc_sequencer (
        .clk(clk), .rst_n(rst_n), .run(run), .opcode(opcode), .funct(funct),
        .pc_src(pc_src), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .ir_we(ir_we), .mem_addr_sel(mem_addr_sel), .mem_re(mem_re),
        .mem_we(mem_we), .wb_from_mem(wb_from_mem), .dst_sel_rd(dst_sel_rd),
        .rf_we(rf_we), .halt(halt), .error(error)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    m_upc  = 0;
    string m_tag  = "R1";
    bit    done   = 0;

    // Dispatch targets as listed in R7, R8 and R12.
    function automatic int exp_target(logic [5:0] op, logic [5:0] fn);
        if (op == 6'h00) begin
            case (fn)
                6'h20: return 2;
                6'h22: return 4;
                6'h24: return 6;
                6'h25: return 8;
                6'h27: return 10;
                6'h2A: return 12;
                default: return 32;
            endcase
        end
        case (op)
            6'h08: return 14;
            6'h0C: return 16;
            6'h0D: return 18;
            6'h0A: return 20;
            6'h0F: return 22;
            6'h23: return 24;
            6'h2B: return 27;
            6'h04: return 29;
            6'h02: return 30;
            6'h20: return 31;
            6'h3F: return 33;
            default: return 32;
        endcase
    endfunction

    // Port view packed at the R2 bit positions, bits 3:0 zero.
    function automatic logic [23:0] port_word();
        return {pc_src, pc_we, pc_we_cond, alu_op, alu_a_sel, alu_b_sel,
                ir_we, mem_addr_sel, mem_re, mem_we, wb_from_mem, dst_sel_rd,
                rf_we, halt, error, 4'h0};
    endfunction

    // Expected port view for a micro-address (error per R10).
    function automatic logic [23:0] exp_word(int a);
        logic [23:0] w;
        w = uc_pkg::ucode_word(a);
        return {w[23:5], w[4] | (w[1:0] == 2'b11), 4'h0};
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %06h expected %06h (uaddr %0d)", tag, act, exp, m_upc);
        end
    endtask

    // Reference model: next micro-address on every rising edge.
    always @(posedge clk) begin
        logic [23:0] w;
        cycles++;
        w = uc_pkg::ucode_word(m_upc);
        if (!rst_n) begin
            m_upc = 0; m_tag = "R1";
        end else if (w[5]) begin
            m_tag = "R9";
        end else if (!run) begin
            m_tag = "R11";
        end else begin
            case (w[1:0])
                2'b00: begin m_upc = 0; m_tag = "R3"; end
                2'b01: begin m_upc = (m_upc + 1) % 4096; m_tag = "R4"; end
                2'b10: begin
                    m_upc = exp_target(opcode, funct);
                    m_tag = (opcode == 0) ? "R8" : "R7";
                    if (m_upc == 32) m_tag = "R12";
                end
                default: begin m_upc = 0; m_tag = "R10"; end
            endcase
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (!done) check(m_tag, port_word(), exp_word(m_upc));
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most 20000", cycles);
            finish_run();
        end
    end

    task automatic instr(logic [5:0] op, logic [5:0] fn, int n);
        @(negedge clk);
        opcode = op; funct = fn;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b1; opcode = '0; funct = '0;
        repeat (3) @(negedge clk);
        // R1, R6: reset state shows the fetch word.
        check("R1", port_word(), 24'h223400);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: decode word follows fetch.
        check("R6", port_word(), 24'h026000);

        // R8: register-format routines.
        instr(6'h00, 6'h20, 8);
        instr(6'h00, 6'h22, 8);
        instr(6'h00, 6'h24, 8);
        instr(6'h00, 6'h25, 8);
        instr(6'h00, 6'h27, 8);
        instr(6'h00, 6'h2A, 8);
        // R7: opcode routines (funct varies to show it is ignored).
        instr(6'h08, 6'h20, 8);
        instr(6'h0C, 6'h3B, 8);
        instr(6'h0D, 6'h00, 8);
        instr(6'h0A, 6'h22, 8);
        instr(6'h0F, 6'h11, 8);
        instr(6'h23, 6'h00, 8);
        instr(6'h2B, 6'h00, 8);
        instr(6'h04, 6'h00, 8);
        instr(6'h02, 6'h00, 8);
        // R12: unlisted opcode and function code.
        instr(6'h11, 6'h00, 8);
        instr(6'h00, 6'h3B, 8);
        // R10: illegal sequencing word.
        instr(6'h3F, 6'h00, 8);

        // R11: stall in the middle of a load routine.
        instr(6'h23, 6'h00, 1);
        repeat (3) @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
        run = 1'b1;
        repeat (6) @(negedge clk);

        // R9: halt holds with run toggling, then reset clears it.
        instr(6'h20, 6'h00, 6);
        checks++;
        if (halt !== 1'b1) begin
            errors++;
            $display("FAIL R9: actual halt %0b expected 1", halt);
        end
        run = 1'b0; repeat (3) @(negedge clk);
        run = 1'b1; opcode = 6'h08; repeat (6) @(negedge clk);
        rst_n = 1'b0; @(negedge clk);
        rst_n = 1'b1;
        // R1: reset during a routine.
        instr(6'h23, 6'h00, 4);
        rst_n = 1'b0; @(negedge clk);
        rst_n = 1'b1; repeat (10) @(negedge clk);

        finish_run();
    end
endmodule